// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the synthesizable front end of a byte-wide serial EEPROM on an I2C bus. A system clock oversamples the bus lines through synchronizers. START and STOP conditions and the SCL edges are found on that sampled copy. The controller answers a device address byte and takes a two-byte word address. It then serves random, current-address and sequential reads, or gathers a page of write data in a buffer. After the STOP that ends a write, the buffered bytes are committed to a synchronous RAM during a self-timed write cycle. For the whole of that cycle the device refuses to acknowledge its own address, so a master can poll for completion.

The address width is the parameter `ADDR_W`. The most significant address bit comes from a block-select bit in the device address byte. The two address bytes supply the remaining bits. `ADDR_W = 17` gives the full 128 KB array. The default is kept small so that the RAM stays light.

Two kinds of write protection apply. A hardware pin makes the whole array read-only. A volatile level register, written over the bus, locks the upper quarter, the upper half or all of the array. Protected or pin-blocked writes still acknowledge their data bytes, but they commit nothing and start no timed cycle.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the controller leaves SDA released, is not in a write cycle, and has protection level 0 (unprotected).
- R2: A device address byte is accepted only when bits [7:4] equal 4'b1010 (memory access) or 4'b0110 (protection register, write only) and bits [2:1] equal `CHIP_SEL`. Bit 0 is read (1) or write (0). On a mismatch the byte gets NACK and SDA stays released until the next START.
- R3: Bit [3] of a memory device address byte becomes address bit `ADDR_W-1`, so the same word address reaches a different half of the array.
- R4: After a write-mode device address, a high byte (its low `ADDR_W-9` bits used) and then a low byte set the address. A repeated START followed by a read-mode address returns the byte stored there.
- R5: A page write buffers up to `PAGE_BYTES` acknowledged data bytes and commits them only after STOP. Within a page the address wraps on its low log2(`PAGE_BYTES`) bits, so bytes past the page end land at the start of the same page.
- R6: A sequential read sends MSB first. After each byte the master acknowledges, it advances the full address, crossing pages and wrapping from the top address to 0. A master NACK ends the read.
- R7: The STOP that ends a committing write starts a write cycle of `WRITE_CYCLES` clocks. During that cycle every device address byte gets NACK, and the address is acknowledged again once the cycle ends.
- R8: When `wp_i` is high at the STOP, the write data bytes are acknowledged, but nothing is committed and no write cycle starts.
- R9: A protection register write takes data bits [1:0]: 0 = none, 1 = upper quarter, 2 = upper half, 3 = whole array. A write to a locked page commits nothing and starts no write cycle. Unlocked pages are written normally.
- R10: A STOP in the middle of a data byte commits only the complete bytes before it. A repeated START during a write discards the pending data, so nothing is committed.
- R11: The controller changes SDA only while SCL is low, and it drives its ACK in the ninth clock of each accepted byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| wp_i | input | 1 | Hardware write protect, active high |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open-drain enable) |

## Verification
The bench polls right after each write. A controller that committed without a timed cycle, or that acknowledged during it, would show zero NACK polls. The bench writes across the end of a page and then reads across that boundary. Wrapping on the full address would corrupt the next page, and wrapping a read on the page bits would return the wrong neighbour. The bench writes with the pin held high and writes into each protected region. Any commit would change the read-back value, and any wrongly started cycle would produce a NACK poll. The bench also stops a write in the middle of a byte, and interrupts one with a repeated START. A design that stored the partial byte, or committed the discarded data, would change bytes that must keep their old contents.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_AHI, S_ALO, S_WDAT, S_RDAT, S_RACK, S_CFG
  } bus_st_t;

  typedef enum logic [1:0] {
    PROT_NONE, PROT_QUARTER, PROT_HALF, PROT_ALL
  } prot_lvl_t;

  localparam logic [3:0] CODE_MEM = 4'b1010;
  localparam logic [3:0] CODE_CFG = 4'b0110;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_N-1:0] scl_sy, sda_sy;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_N-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC_N-2:0], sda_i};
      scl_d  <= scl_sy[SYNC_N-1];
      sda_d  <= sda_sy[SYNC_N-1];
    end
  end

  assign scl_q     = scl_sy[SYNC_N-1];
  assign sda_q     = sda_sy[SYNC_N-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/eeprom_region_guard.sv
module eeprom_region_guard
  import eeprom_pkg::*;
#(
  parameter int AW = 12
) (
  input  prot_lvl_t       lvl,
  input  logic [AW-1:0]   addr,
  output logic            locked
);
  always_comb begin
    unique case (lvl)
      PROT_NONE:    locked = 1'b0;
      PROT_QUARTER: locked = &addr[AW-1:AW-2];
      PROT_HALF:    locked = addr[AW-1];
      default:      locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int         ADDR_W       = 12,
  parameter int         PAGE_BYTES   = 64,
  parameter int         WRITE_CYCLES = 600,
  parameter logic [1:0] CHIP_SEL     = 2'b00,
  parameter int         SYNC_N       = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe_o
);
  localparam int PW   = $clog2(PAGE_BYTES);
  localparam int CI_W = PW + 1;
  localparam int HI_W = ADDR_W - 9;
  localparam int TW   = $clog2(WRITE_CYCLES + 1);

  logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  bus_st_t               st;
  logic [3:0]            bitcnt;
  logic                  ack_ph, mack, pending, busy;
  logic [7:0]            shreg, txreg;
  logic [ADDR_W-1:0]     addr;
  logic [ADDR_W-PW-1:0]  page_q;
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pvalid;
  logic [TW-1:0]         tmr;
  logic [CI_W-1:0]       cidx;
  prot_lvl_t             prot_lvl;
  logic [7:0]            rd_byte;
  logic                  page_locked;

  // page-level lock: regions are page aligned
  eeprom_region_guard #(.AW(ADDR_W)) u_guard (
    .lvl(prot_lvl),
    .addr({addr[ADDR_W-1:PW], {PW{1'b0}}}),
    .locked(page_locked)
  );

  // commit engine walks the page buffer during the timed cycle
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  assign mem_we    = busy && (cidx < CI_W'(PAGE_BYTES)) && pvalid[cidx[PW-1:0]];
  assign mem_waddr = {page_q, cidx[PW-1:0]};

  eeprom_store #(.AW(ADDR_W), .DW(8)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(pbuf[cidx[PW-1:0]]),
    .raddr(addr), .rdata(rd_byte)
  );

  // acknowledge decision for a completed received byte
  logic    byte_take;
  bus_st_t byte_next;
  always_comb begin
    byte_take = 1'b0;
    byte_next = S_IDLE;
    unique case (st)
      S_DEV: if (!busy && shreg[2:1] == CHIP_SEL) begin
        if (shreg[7:4] == CODE_MEM) begin
          byte_take = 1'b1;
          byte_next = shreg[0] ? S_RDAT : S_AHI;
        end else if (shreg[7:4] == CODE_CFG && !shreg[0]) begin
          byte_take = 1'b1;
          byte_next = S_CFG;
        end
      end
      S_AHI:  begin byte_take = 1'b1; byte_next = S_ALO;  end
      S_ALO:  begin byte_take = 1'b1; byte_next = S_WDAT; end
      S_WDAT: begin byte_take = 1'b1; byte_next = S_WDAT; end
      S_CFG:  begin byte_take = 1'b1; byte_next = S_CFG;  end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      bitcnt   <= '0;
      ack_ph   <= 1'b0;
      mack     <= 1'b0;
      pending  <= 1'b0;
      busy     <= 1'b0;
      shreg    <= '0;
      txreg    <= '0;
      addr     <= '0;
      page_q   <= '0;
      pvalid   <= '0;
      tmr      <= '0;
      cidx     <= '0;
      prot_lvl <= PROT_NONE;
      sda_oe_o <= 1'b0;
    end else begin
      if (busy) begin
        if (cidx < CI_W'(PAGE_BYTES)) cidx <= cidx + 1'b1;
        if (tmr == TW'(WRITE_CYCLES - 1)) busy <= 1'b0;
        else tmr <= tmr + 1'b1;
      end
      if (stop_det) begin
        if (st == S_WDAT && pending && !wp_i && !page_locked) begin
          busy   <= 1'b1;
          tmr    <= '0;
          cidx   <= '0;
          page_q <= addr[ADDR_W-1:PW];
        end
        st       <= S_IDLE;
        pending  <= 1'b0;
        ack_ph   <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (start_det) begin
        st       <= S_DEV;
        bitcnt   <= '0;
        pending  <= 1'b0;
        ack_ph   <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (st != S_IDLE) begin
        if (ack_ph) begin
          if (scl_fall) begin
            ack_ph <= 1'b0;
            if (st == S_RDAT) begin
              txreg    <= {rd_byte[6:0], 1'b0};
              sda_oe_o <= ~rd_byte[7];
              bitcnt   <= 4'd1;
            end else begin
              sda_oe_o <= 1'b0;
              bitcnt   <= '0;
            end
          end
        end else if (st == S_RDAT) begin
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe_o <= 1'b0;
              st       <= S_RACK;
            end else begin
              sda_oe_o <= ~txreg[7];
              txreg    <= {txreg[6:0], 1'b0};
              bitcnt   <= bitcnt + 1'b1;
            end
          end
        end else if (st == S_RACK) begin
          if (scl_rise) begin
            mack <= ~sda_q;
            if (!sda_q) addr <= addr + 1'b1;
          end else if (scl_fall) begin
            if (mack) begin
              txreg    <= {rd_byte[6:0], 1'b0};
              sda_oe_o <= ~rd_byte[7];
              bitcnt   <= 4'd1;
              st       <= S_RDAT;
            end else begin
              st <= S_IDLE;
            end
          end
        end else begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_q};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt <= '0;
            if (byte_take) begin
              sda_oe_o <= 1'b1;
              ack_ph   <= 1'b1;
              st       <= byte_next;
              unique case (st)
                S_DEV:  if (shreg[7:4] == CODE_MEM) addr[ADDR_W-1] <= shreg[3];
                S_AHI:  addr[ADDR_W-2:8] <= shreg[HI_W-1:0];
                S_ALO:  begin addr[7:0] <= shreg; pvalid <= '0; end
                S_WDAT: begin
                  pbuf[addr[PW-1:0]]   <= shreg;
                  pvalid[addr[PW-1:0]] <= 1'b1;
                  addr[PW-1:0]         <= addr[PW-1:0] + 1'b1;
                  pending              <= 1'b1;
                end
                S_CFG:  prot_lvl <= prot_lvl_t'(shreg[1:0]);
                default: ;
              endcase
            end else begin
              st <= S_IDLE;
            end
          end
        end
      end
    end
  end

  // R7
  busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe_o);
  // R7
  cycle_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_det));
  // R8
  wp_no_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(wp_i));
  // R9
  lock_no_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(page_locked));
  // R11
  drive_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> !scl_q);
  // R2
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> !sda_oe_o);
endmodule

// File: tb/i2c_eeprom_slave_test.sv
module i2c_eeprom_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [1:0] CS = 2'b10;

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, sda_line;
  int n_chk = 0, n_fail = 0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_eeprom_slave #(.ADDR_W(12), .PAGE_BYTES(64), .WRITE_CYCLES(600),
                     .CHIP_SEL(CS)) uut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .wp_i(wp),
    .sda_oe_o(sda_oe)
  );

  // address, data
  localparam logic [19:0] VEC [6] = '{
    {12'h000, 8'h3C}, {12'h3FF, 8'hA5}, {12'h5C1, 8'h11},
    {12'h800, 8'h7E}, {12'hC3F, 8'hC9}, {12'hFFF, 8'h02}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask
  task automatic bus_start();
    sda_m = 1'b1; qw(); scl = 1'b1; qw(); sda_m = 1'b0; qw(); scl = 1'b0; qw();
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask
  task automatic put_bit(input logic b);
    sda_m = b; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1'b1; qw(); scl = 1'b1; qw(); b = sda_line; qw(); scl = 1'b0; qw();
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    ack = !a;
  endtask
  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(!give_ack);
  endtask

  function automatic logic [7:0] dev(input logic [11:0] a, input logic rw);
    return {4'hA, a[11], CS, rw};
  endfunction

  task automatic write_bytes(input logic [11:0] a, input int n, output logic dev_ack);
    logic k;
    bus_start();
    send_byte(dev(a, 1'b0), dev_ack);
    if (dev_ack) begin
      send_byte({5'b0, a[10:8]}, k);
      send_byte(a[7:0], k);
      for (int i = 0; i < n; i++) send_byte(wbuf[i], k);
    end
    bus_stop();
  endtask

  task automatic read_bytes(input logic [11:0] a, input int n);
    logic k;
    bus_start();
    send_byte(dev(a, 1'b0), k);
    send_byte({5'b0, a[10:8]}, k);
    send_byte(a[7:0], k);
    bus_start();
    send_byte(dev(a, 1'b1), k);
    for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic wait_ready(output int polls);
    logic k;
    polls = 0;
    for (int i = 0; i < 50; i++) begin
      bus_start();
      send_byte(dev(12'h000, 1'b0), k);
      bus_stop();
      if (k) break;
      polls++;
    end
  endtask

  task automatic set_prot(input logic [1:0] lvl);
    logic k;
    bus_start();
    send_byte({4'b0110, 1'b0, CS, 1'b0}, k);
    send_byte({6'b0, lvl}, k);
    bus_stop();
    chk(k, "R9 cfg ack", k, 1);
  endtask

  task automatic wr1(input logic [11:0] a, input logic [7:0] d, output int polls);
    logic k;
    wbuf[0] = d;
    write_bytes(a, 1, k);
    wait_ready(polls);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic k;
    int polls;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);

    // table walk: write, poll, random read back
    foreach (VEC[i]) begin
      wbuf[0] = VEC[i][7:0];
      write_bytes(VEC[i][19:8], 1, k);
      chk(k, "R2 dev ack", k, 1);
      chk(k, "R11 ack in ninth clock", k, 1);
      wait_ready(polls);
      chk(polls > 0 && polls < 50, "R7 busy polls", polls, 1);
      read_bytes(VEC[i][19:8], 1);
      chk(rbuf[0] == VEC[i][7:0], "R4 random read", rbuf[0], VEC[i][7:0]);
    end

    // block select
    wr1(12'h805, 8'h55, polls);
    wr1(12'h005, 8'hAA, polls);
    read_bytes(12'h805, 1);
    chk(rbuf[0] == 8'h55, "R3 upper block", rbuf[0], 8'h55);
    read_bytes(12'h005, 1);
    chk(rbuf[0] == 8'hAA, "R3 lower block", rbuf[0], 8'hAA);

    // address mismatch
    bus_start(); send_byte({4'hA, 1'b0, 2'b01, 1'b0}, k); bus_stop();
    chk(!k, "R2 chip select mismatch", k, 0);
    bus_start(); send_byte({4'h5, 1'b0, CS, 1'b0}, k); bus_stop();
    chk(!k, "R2 control code mismatch", k, 0);

    // page wrap and sequential read across the page boundary
    wr1(12'h1C0, 8'h77, polls);
    wbuf[0] = 8'hE0; wbuf[1] = 8'hE1; wbuf[2] = 8'hE2; wbuf[3] = 8'hE3;
    write_bytes(12'h1BE, 4, k);
    wait_ready(polls);
    read_bytes(12'h1BE, 3);
    chk(rbuf[0] == 8'hE0, "R6 seq byte0", rbuf[0], 8'hE0);
    chk(rbuf[1] == 8'hE1, "R6 seq byte1", rbuf[1], 8'hE1);
    chk(rbuf[2] == 8'h77, "R5 next page untouched", rbuf[2], 8'h77);
    read_bytes(12'h180, 2);
    chk(rbuf[0] == 8'hE2, "R5 wrap byte2", rbuf[0], 8'hE2);
    chk(rbuf[1] == 8'hE3, "R5 wrap byte3", rbuf[1], 8'hE3);

    // sequential read across the top of the array
    read_bytes(12'hFFF, 2);
    chk(rbuf[0] == 8'h02, "R6 top byte", rbuf[0], 8'h02);
    chk(rbuf[1] == 8'h3C, "R6 wrap to zero", rbuf[1], 8'h3C);

    // hardware write protect
    wp = 1'b1;
    wr1(12'h000, 8'hEE, polls);
    chk(polls == 0, "R8 no cycle", polls, 0);
    wp = 1'b0;
    read_bytes(12'h000, 1);
    chk(rbuf[0] == 8'h3C, "R8 no commit", rbuf[0], 8'h3C);

    // software protection levels
    set_prot(2'd1);
    wr1(12'hC3F, 8'h00, polls);
    chk(polls == 0, "R9 quarter no cycle", polls, 0);
    read_bytes(12'hC3F, 1);
    chk(rbuf[0] == 8'hC9, "R9 quarter locked", rbuf[0], 8'hC9);
    wr1(12'h800, 8'h81, polls);
    read_bytes(12'h800, 1);
    chk(rbuf[0] == 8'h81, "R9 quarter leaves half", rbuf[0], 8'h81);
    set_prot(2'd2);
    wr1(12'h800, 8'h82, polls);
    read_bytes(12'h800, 1);
    chk(rbuf[0] == 8'h81, "R9 half locked", rbuf[0], 8'h81);
    wr1(12'h3FF, 8'h5A, polls);
    read_bytes(12'h3FF, 1);
    chk(rbuf[0] == 8'h5A, "R9 lower half open", rbuf[0], 8'h5A);
    set_prot(2'd3);
    wr1(12'h000, 8'h01, polls);
    chk(polls == 0, "R9 all no cycle", polls, 0);
    read_bytes(12'h000, 1);
    chk(rbuf[0] == 8'h3C, "R9 all locked", rbuf[0], 8'h3C);
    set_prot(2'd0);
    wr1(12'h000, 8'h3D, polls);
    read_bytes(12'h000, 1);
    chk(rbuf[0] == 8'h3D, "R9 unlocked again", rbuf[0], 8'h3D);

    // abort mid-byte with STOP
    wbuf[0] = 8'h10; wbuf[1] = 8'h20;
    write_bytes(12'h200, 2, k);
    wait_ready(polls);
    bus_start();
    send_byte(dev(12'h200, 1'b0), k);
    send_byte(8'h02, k);
    send_byte(8'h00, k);
    send_byte(8'h44, k);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    wait_ready(polls);
    read_bytes(12'h200, 2);
    chk(rbuf[0] == 8'h44, "R10 complete byte kept", rbuf[0], 8'h44);
    chk(rbuf[1] == 8'h20, "R10 partial byte dropped", rbuf[1], 8'h20);

    // repeated START discards the pending write
    bus_start();
    send_byte(dev(12'h200, 1'b0), k);
    send_byte(8'h02, k);
    send_byte(8'h00, k);
    send_byte(8'h66, k);
    bus_start();
    send_byte(dev(12'h200, 1'b1), k);
    recv_byte(1'b0, rbuf[0]);
    bus_stop();
    wait_ready(polls);
    chk(polls == 0, "R10 discard no cycle", polls, 0);
    read_bytes(12'h200, 1);
    chk(rbuf[0] == 8'h44, "R10 discard no commit", rbuf[0], 8'h44);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule